// File: doc/BRIEF.md
# Dual-Port Block Memory with Selectable Write Modes

This block is a 4.5 Kbit synchronous memory with two independent access ports, A and B, on one shared clock. A parameter sets the word width to 1, 2, 4, 9, 18 or 36 bits, and the depth and address width follow from it. On every clock edge each port samples its enable, write enable, address and write data. Read data returns one cycle later. When the port's optional output stage is enabled, read data returns two cycles later.

Each port has its own write mode, which decides what the port's data output shows after a write. In normal mode the output is left alone. In echo mode the output shows the word just written. In old-data mode the output shows what the address held before the write. The array can start from a computed pattern instead of zeros. A lock parameter turns the block into a read-only table. At 36 bits port B can only read, so the block works as a simple dual-port memory at that width.

The ports have no handshake. An enabled port accepts one access on every clock, and there is no back-pressure, so the caller owns the scheduling. The two ports must not write the same address in the same cycle: the word stored in that case is undefined.

Top module: `bram_dp`

## Requirements
- R1: `DATA_W` sets the depth: width 1 gives 4096 words, 2 gives 2048, 4 gives 1024, 9 gives 512, 18 gives 256 and 36 gives 128. The address width is log2 of the depth, and the highest address stores and returns data like any other.
- R2: An access with `x_en`=1 sampled at edge N updates the port output just after edge N when the port's output stage is off. When the stage is on, the output updates just after edge N+1.
- R3: Normal mode (`WM_NORMAL`=0): a read (`x_en`=1, `x_we`=0) returns the stored word, and a write stores data while the port output keeps its previous value.
- R4: Echo mode (`WM_THRU`=1): a write stores data and puts the written word on the same port's output.
- R5: Old-data mode (`WM_OLDFIRST`=2): a write puts the address's previous contents on the same port's output. A later read returns the new word.
- R6: A port with `x_en`=0 neither writes nor changes its output, whatever `x_we`, address and data carry.
- R7: When one port reads an address in the same cycle that the other port writes it, the read returns the previous contents. The next read returns the new word.
- R8: With `DATA_W`=36, port B writes are ignored. An access with `b_we`=1 behaves as a read on port B.
- R9: With `PRELOAD`=1, word i holds the low `DATA_W` bits of i*37+5 before any write. With `PRELOAD`=0 all words start at zero.
- R10: With `ROM`=1, `x_we` is ignored on both ports. Every enabled access is a read and the contents never change.
- R11: While `rst_n` is low, both data outputs are zero. Reset does not touch the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable (needs a_en) |
| a_addr | input | AW (9 by default) | Port A word address |
| a_wdata | input | DATA_W (9) | Port A write data |
| a_rdata | output | DATA_W (9) | Port A data output |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable (needs b_en; ignored at 36 bits) |
| b_addr | input | AW (9 by default) | Port B word address |
| b_wdata | input | DATA_W (9) | Port B write data |
| b_rdata | output | DATA_W (9) | Port B data output |

## Verification
The assertions inside each port stage check five things on every cycle: the read latency with and without the output stage, that a normal-mode write leaves the output as it was, the echo of written data, the old-data output on a write, and that a disabled port holds its output. Some behaviours show only in the bench's scenarios, because they depend on what the array holds over many cycles. These are the preload pattern, writes being ignored in the locked table and on the 36-bit port B, the ordering between ports at one address, and access to the highest address. Three configurations are compared every cycle against a behavioural model under random traffic.

// File: rtl/bram_pkg.sv
package bram_pkg;

  // Output behaviour of a port on a write cycle.
  typedef enum logic [1:0] {
    WM_NORMAL   = 2'd0,  // output untouched by writes
    WM_THRU     = 2'd1,  // output shows the word being written
    WM_OLDFIRST = 2'd2   // output shows the word being replaced
  } wmode_e;

  localparam int TOTAL_BITS = 4608;

  // Depth for each legal word width; 0 flags an illegal width.
  function automatic int depth_of(int w);
    case (w)
      1:       return 4096;
      2:       return 2048;
      4:       return 1024;
      9:       return 512;
      18:      return 256;
      36:      return 128;
      default: return 0;
    endcase
  endfunction

  function automatic int abits_of(int w);
    return (depth_of(w) > 1) ? $clog2(depth_of(w)) : 1;
  endfunction

  // Initial content pattern used when preloading is selected.
  function automatic logic [35:0] preload_word(int idx);
    return 36'(idx * 37 + 5);
  endfunction

endpackage

// File: rtl/bram_core.sv
module bram_core import bram_pkg::*; #(
  parameter int DW      = 9,
  parameter int DEPTH   = 512,
  parameter int AW      = 9,
  parameter bit PRELOAD = 1'b0
) (
  input  logic          clk,
  input  logic          wr_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] wdata_a,
  output logic [DW-1:0] rd_a,
  input  logic          wr_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] wdata_b,
  output logic [DW-1:0] rd_b
);

  logic [DW-1:0] store [DEPTH];

  // Power-up content, computed rather than loaded from a file.
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      store[i] <= PRELOAD ? DW'(preload_word(i)) : '0;
    end
  end

  // One process owns the array; port B is applied after port A.
  always @(posedge clk) begin
    if (wr_a) store[addr_a] <= wdata_a;
    if (wr_b) store[addr_b] <= wdata_b;
  end

  // Current contents at each address; the lane register samples these
  // at the same edge that commits any write, so it sees the old word.
  assign rd_a = store[addr_a];
  assign rd_b = store[addr_b];

endmodule

// File: rtl/bram_lane.sv
module bram_lane import bram_pkg::*; #(
  parameter int     DW   = 9,
  parameter wmode_e MODE = WM_NORMAL,
  parameter bit     OREG = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,       // already gated by lock rules
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rd_word,  // array word at the sampled address
  output logic [DW-1:0] dout
);

  logic          load;
  logic [DW-1:0] nxt;
  logic [DW-1:0] lat_q;

  always_comb begin
    case (MODE)
      WM_NORMAL: begin
        load = en && !we;
        nxt  = rd_word;
      end
      WM_THRU: begin
        load = en;
        nxt  = we ? wdata : rd_word;
      end
      default: begin
        load = en;
        nxt  = rd_word;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat_q <= '0;
    else if (load) lat_q <= nxt;
  end

  generate
    if (OREG) begin : g_oreg
      logic [DW-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= lat_q;
      end
      assign dout = pipe_q;

      p_read_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !we) |-> ##2 (dout == $past(rd_word, 2)));
    end else begin : g_direct
      assign dout = lat_q;

      p_read_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !we) |=> (dout == $past(rd_word)));
    end

    if (MODE == WM_NORMAL) begin : g_chk_normal
      p_write_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> $stable(lat_q));
    end else if (MODE == WM_THRU) begin : g_chk_thru
      p_write_echo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> (lat_q == $past(wdata)));
    end else begin : g_chk_old
      p_old_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && we) |=> (lat_q == $past(rd_word)));
    end
  endgenerate

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(lat_q));

endmodule

// File: rtl/bram_dp.sv
module bram_dp import bram_pkg::*; #(
  parameter int     DATA_W    = 9,
  parameter wmode_e MODE_A    = WM_NORMAL,
  parameter wmode_e MODE_B    = WM_OLDFIRST,
  parameter bit     OUT_REG_A = 1'b0,
  parameter bit     OUT_REG_B = 1'b1,
  parameter bit     PRELOAD   = 1'b0,
  parameter bit     ROM       = 1'b0,
  localparam int    DEPTH     = depth_of(DATA_W),
  localparam int    AW        = abits_of(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [AW-1:0]     b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  // The widest shape leaves port B without a write path.
  localparam bit B_WRITABLE = (DATA_W != 36);

  generate
    if (DEPTH == 0) begin : g_bad_width
      $error("bram_dp: DATA_W must be 1, 2, 4, 9, 18 or 36");
    end
  endgenerate

  logic              wr_a, wr_b;
  logic [DATA_W-1:0] rd_a, rd_b;

  assign wr_a = a_en && a_we && !ROM;
  assign wr_b = b_en && b_we && !ROM && B_WRITABLE;

  bram_core #(
    .DW      (DATA_W),
    .DEPTH   (DEPTH),
    .AW      (AW),
    .PRELOAD (PRELOAD)
  ) u_core (
    .clk     (clk),
    .wr_a    (wr_a),
    .addr_a  (a_addr),
    .wdata_a (a_wdata),
    .rd_a    (rd_a),
    .wr_b    (wr_b),
    .addr_b  (b_addr),
    .wdata_b (b_wdata),
    .rd_b    (rd_b)
  );

  bram_lane #(
    .DW   (DATA_W),
    .MODE (MODE_A),
    .OREG (OUT_REG_A)
  ) u_lane_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (a_en),
    .we      (wr_a),
    .wdata   (a_wdata),
    .rd_word (rd_a),
    .dout    (a_rdata)
  );

  bram_lane #(
    .DW   (DATA_W),
    .MODE (MODE_B),
    .OREG (OUT_REG_B)
  ) u_lane_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (b_en),
    .we      (wr_b),
    .wdata   (b_wdata),
    .rd_word (rd_b),
    .dout    (b_rdata)
  );

endmodule

// File: tb/sim_ref.sv
module sim_ref #(
  parameter int W   = 9,
  parameter int N   = 512,
  parameter int AW  = 9,
  parameter int MA  = 0,
  parameter int MB  = 0,
  parameter int OA  = 0,
  parameter int OB  = 0,
  parameter int PRE = 0,
  parameter int RO  = 0,
  parameter int BRO = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [W-1:0]  b_wdata,
  output logic [W-1:0]  a_q,
  output logic [W-1:0]  b_q
);
  logic [W-1:0] mem [N];
  logic [W-1:0] la, lb, pa, pb, oa, ob;
  bit wa, wb;

  initial for (int i = 0; i < N; i++) mem[i] = (PRE != 0) ? W'(i * 37 + 5) : '0;

  function automatic logic [W-1:0] pick(int mode, bit en, bit wr,
                                        logic [W-1:0] cur, logic [W-1:0] old,
                                        logic [W-1:0] nw);
    if (!en) return cur;
    if (mode == 0) return wr ? cur : old;
    if (mode == 1) return wr ? nw : old;
    return old;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      la = '0; lb = '0; pa = '0; pb = '0;
    end else begin
      oa = mem[a_addr];
      ob = mem[b_addr];
      wa = a_en && a_we && (RO == 0);
      wb = b_en && b_we && (RO == 0) && (BRO == 0);
      pa = la;
      pb = lb;
      la = pick(MA, a_en, wa, la, oa, a_wdata);
      lb = pick(MB, b_en, wb, lb, ob, b_wdata);
      if (wa) mem[a_addr] = a_wdata;
      if (wb) mem[b_addr] = b_wdata;
    end
  end

  assign a_q = (OA != 0) ? pa : la;
  assign b_q = (OB != 0) ? pb : lb;
endmodule

// File: tb/sim_bram_dp.sv
`timescale 1ns/1ps
module sim_bram_dp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // u0: 9 bits, A normal direct, B old-data with output stage
  logic p0_a_en = 0, p0_a_we = 0, p0_b_en = 0, p0_b_we = 0;
  logic [8:0] p0_a_addr = '0, p0_b_addr = '0, p0_a_wd = '0, p0_b_wd = '0;
  logic [8:0] p0_a_q, p0_b_q, m0_a, m0_b;
  // u1: 36 bits, preloaded, A echo with output stage, B normal direct
  logic p1_a_en = 0, p1_a_we = 0, p1_b_en = 0, p1_b_we = 0;
  logic [6:0] p1_a_addr = '0, p1_b_addr = '0;
  logic [35:0] p1_a_wd = '0, p1_b_wd = '0;
  logic [35:0] p1_a_q, p1_b_q, m1_a, m1_b;
  // u2: 2 bits, preloaded, locked table, A echo, B old-data
  logic p2_a_en = 0, p2_a_we = 0, p2_b_en = 0, p2_b_we = 0;
  logic [10:0] p2_a_addr = '0, p2_b_addr = '0;
  logic [1:0] p2_a_wd = '0, p2_b_wd = '0;
  logic [1:0] p2_a_q, p2_b_q, m2_a, m2_b;

  bram_dp #(.DATA_W(9), .MODE_A(bram_pkg::WM_NORMAL), .MODE_B(bram_pkg::WM_OLDFIRST),
            .OUT_REG_A(1'b0), .OUT_REG_B(1'b1), .PRELOAD(1'b0), .ROM(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_en(p0_a_en), .a_we(p0_a_we), .a_addr(p0_a_addr), .a_wdata(p0_a_wd), .a_rdata(p0_a_q),
    .b_en(p0_b_en), .b_we(p0_b_we), .b_addr(p0_b_addr), .b_wdata(p0_b_wd), .b_rdata(p0_b_q));

  bram_dp #(.DATA_W(36), .MODE_A(bram_pkg::WM_THRU), .MODE_B(bram_pkg::WM_NORMAL),
            .OUT_REG_A(1'b1), .OUT_REG_B(1'b0), .PRELOAD(1'b1), .ROM(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n),
    .a_en(p1_a_en), .a_we(p1_a_we), .a_addr(p1_a_addr), .a_wdata(p1_a_wd), .a_rdata(p1_a_q),
    .b_en(p1_b_en), .b_we(p1_b_we), .b_addr(p1_b_addr), .b_wdata(p1_b_wd), .b_rdata(p1_b_q));

  bram_dp #(.DATA_W(2), .MODE_A(bram_pkg::WM_THRU), .MODE_B(bram_pkg::WM_OLDFIRST),
            .OUT_REG_A(1'b0), .OUT_REG_B(1'b0), .PRELOAD(1'b1), .ROM(1'b1)) u2 (
    .clk(clk), .rst_n(rst_n),
    .a_en(p2_a_en), .a_we(p2_a_we), .a_addr(p2_a_addr), .a_wdata(p2_a_wd), .a_rdata(p2_a_q),
    .b_en(p2_b_en), .b_we(p2_b_we), .b_addr(p2_b_addr), .b_wdata(p2_b_wd), .b_rdata(p2_b_q));

  sim_ref #(.W(9), .N(512), .AW(9), .MA(0), .MB(2), .OA(0), .OB(1), .PRE(0), .RO(0), .BRO(0)) r0 (
    .clk(clk), .rst_n(rst_n),
    .a_en(p0_a_en), .a_we(p0_a_we), .a_addr(p0_a_addr), .a_wdata(p0_a_wd),
    .b_en(p0_b_en), .b_we(p0_b_we), .b_addr(p0_b_addr), .b_wdata(p0_b_wd),
    .a_q(m0_a), .b_q(m0_b));

  sim_ref #(.W(36), .N(128), .AW(7), .MA(1), .MB(0), .OA(1), .OB(0), .PRE(1), .RO(0), .BRO(1)) r1 (
    .clk(clk), .rst_n(rst_n),
    .a_en(p1_a_en), .a_we(p1_a_we), .a_addr(p1_a_addr), .a_wdata(p1_a_wd),
    .b_en(p1_b_en), .b_we(p1_b_we), .b_addr(p1_b_addr), .b_wdata(p1_b_wd),
    .a_q(m1_a), .b_q(m1_b));

  sim_ref #(.W(2), .N(2048), .AW(11), .MA(1), .MB(2), .OA(0), .OB(0), .PRE(1), .RO(1), .BRO(0)) r2 (
    .clk(clk), .rst_n(rst_n),
    .a_en(p2_a_en), .a_we(p2_a_we), .a_addr(p2_a_addr), .a_wdata(p2_a_wd),
    .b_en(p2_b_en), .b_we(p2_b_we), .b_addr(p2_b_addr), .b_wdata(p2_b_wd),
    .a_q(m2_a), .b_q(m2_b));

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic idle();
    p0_a_en = 0; p0_a_we = 0; p0_b_en = 0; p0_b_we = 0;
    p1_a_en = 0; p1_a_we = 0; p1_b_en = 0; p1_b_we = 0;
    p2_a_en = 0; p2_a_we = 0; p2_b_en = 0; p2_b_we = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Cycle-by-cycle comparison of every output against the models.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("model u0 port A", 36'(p0_a_q), 36'(m0_a));
      chk("model u0 port B", 36'(p0_b_q), 36'(m0_b));
      chk("model u1 port A", p1_a_q, m1_a);
      chk("model u1 port B", p1_b_q, m1_b);
      chk("model u2 port A", 36'(p2_a_q), 36'(m2_a));
      chk("model u2 port B", 36'(p2_b_q), 36'(m2_b));
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: outputs cleared during reset
    chk("R11 u0 a in reset", 36'(p0_a_q), 36'd0);
    chk("R11 u1 a in reset", p1_a_q, 36'd0);
    rst_n = 1;

    // R3 write holds output; R9 preloaded words
    p0_a_en = 1; p0_a_we = 1; p0_a_addr = 9'd5; p0_a_wd = 9'd421;
    p1_b_en = 1; p1_b_addr = 7'd3;
    p2_a_en = 1; p2_a_addr = 11'd10;
    step();
    chk("R3 normal write keeps output", 36'(p0_a_q), 36'd0);
    chk("R9 preload u1 word 3", p1_b_q, 36'd116);
    chk("R9 preload u2 word 10", 36'(p2_a_q), 36'd3);
    idle();
    p0_a_en = 1; p0_a_addr = 9'd5;
    step();
    chk("R2 R3 one-cycle read", 36'(p0_a_q), 36'd421);
    idle();
    p0_b_en = 1; p0_b_we = 1; p0_b_addr = 9'd5; p0_b_wd = 9'd243;
    step();
    chk("R2 output stage not yet updated", 36'(p0_b_q), 36'd0);
    idle();
    p0_b_en = 1; p0_b_addr = 9'd5;
    step();
    chk("R5 old word on write", 36'(p0_b_q), 36'd421);
    idle();
    step();
    chk("R5 new word after write", 36'(p0_b_q), 36'd243);
    // R6 disabled port with write enable set
    p0_a_en = 0; p0_a_we = 1; p0_a_addr = 9'd5; p0_a_wd = 9'd7;
    step();
    chk("R6 disabled port holds", 36'(p0_a_q), 36'd421);
    idle();
    p0_a_en = 1; p0_a_addr = 9'd5;
    step();
    chk("R6 disabled write not stored", 36'(p0_a_q), 36'd243);
    // R7 read-during-write across ports
    idle();
    p0_a_en = 1; p0_a_we = 1; p0_a_addr = 9'd20; p0_a_wd = 9'd300;
    p0_b_en = 1; p0_b_addr = 9'd20;
    step();
    idle();
    step();
    chk("R7 cross read sees old word", 36'(p0_b_q), 36'd0);
    p0_b_en = 1; p0_b_addr = 9'd20;
    step();
    idle();
    step();
    chk("R7 later read sees new word", 36'(p0_b_q), 36'd300);
    // R4 echo through output stage
    p1_a_en = 1; p1_a_we = 1; p1_a_addr = 7'd7; p1_a_wd = 36'h987654321;
    step();
    idle();
    step();
    chk("R4 echo of written word", p1_a_q, 36'h987654321);
    // R8 port B at 36 bits cannot write
    p1_b_en = 1; p1_b_we = 1; p1_b_addr = 7'd7; p1_b_wd = 36'h123456789;
    step();
    chk("R8 port B write acts as read", p1_b_q, 36'h987654321);
    idle();
    p1_b_en = 1; p1_b_addr = 7'd7;
    step();
    chk("R8 port B write not stored", p1_b_q, 36'h987654321);
    // R10 locked table
    idle();
    p2_a_en = 1; p2_a_we = 1; p2_a_addr = 11'd10; p2_a_wd = 2'd0;
    step();
    chk("R10 locked write not echoed", 36'(p2_a_q), 36'd3);
    idle();
    p2_b_en = 1; p2_b_addr = 11'd10;
    step();
    chk("R10 locked contents unchanged", 36'(p2_b_q), 36'd3);
    // R1 highest addresses
    idle();
    p0_a_en = 1; p0_a_we = 1; p0_a_addr = 9'd511; p0_a_wd = 9'd341;
    p1_b_en = 1; p1_b_addr = 7'd127;
    step();
    chk("R1 u1 top word", p1_b_q, 36'd4704);
    idle();
    p0_a_en = 1; p0_a_addr = 9'd511;
    step();
    chk("R1 u0 top word", 36'(p0_a_q), 36'd341);

    // Random traffic, checked by the model comparison above.
    for (int n = 0; n < 3000; n++) begin
      p0_a_en = 1'($urandom); p0_a_we = 1'($urandom);
      p0_b_en = 1'($urandom); p0_b_we = 1'($urandom);
      p0_a_addr = 9'($urandom_range(0, 15)); p0_b_addr = 9'($urandom_range(0, 15));
      p0_a_wd = 9'($urandom); p0_b_wd = 9'($urandom);
      if (p0_a_en && p0_a_we && p0_b_en && p0_b_we && p0_a_addr == p0_b_addr) p0_b_we = 0;
      p1_a_en = 1'($urandom); p1_a_we = 1'($urandom);
      p1_b_en = 1'($urandom); p1_b_we = 1'($urandom);
      p1_a_addr = 7'($urandom_range(0, 15)); p1_b_addr = 7'($urandom_range(0, 15));
      p1_a_wd = {4'($urandom), 32'($urandom)}; p1_b_wd = {4'($urandom), 32'($urandom)};
      p2_a_en = 1'($urandom); p2_a_we = 1'($urandom);
      p2_b_en = 1'($urandom); p2_b_we = 1'($urandom);
      p2_a_addr = 11'($urandom); p2_b_addr = 11'($urandom);
      p2_a_wd = 2'($urandom); p2_b_wd = 2'($urandom);
      step();
    end
    idle();
    step();
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      report();
    end
  end
endmodule